// File: doc/BRIEF.md
# Duty-Cycled Receiver Phase Sequencer

This block steers the RF front-end power of an impulse-radio receiver through one packet. After a start command it keeps the front-end on without a break while the acquisition engine hunts for the preamble code phase. Once acquisition reports the timing of the next preamble pulse, the block turns the front-end on only in a short window around each isolated pulse while the frame-delimiter search runs. When the delimiter is found, it gates the front-end around each payload burst and enables the decoder until the payload is complete. Duty-cycling never starts before acquisition has finished.

Each window opens a programmable number of samples (the guard) ahead of the expected pulse or burst. It stays open for a programmable number of samples. A slot counter advances once per sample clock and repeats with the pulse period while tracking and with the burst period during the payload. Every strobe that fixes timing also carries the number of samples from that strobe to the next expected pulse or burst. The counter is preset from that value, so the windows line up from the very first one. If no delimiter arrives within a programmable number of pulse periods, the block falls back to acquisition.

Top module: `fe_phase_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `phase` reads 0, `fe_en` is low and all three engine enables are low.
- R2: Phase codes are idle=0, sync=1, track=2, payload=3. In idle `fe_en` and all engine enables stay low, and `acq_valid`, `sfd_hit` and `pay_done` are ignored. A `start` sampled in idle moves the phase to sync in the next cycle.
- R3: In sync, `fe_en` is high in every cycle and only `eng_acq_en` is set. `start`, `sfd_hit` and `pay_done` are ignored there.
- R4: An `acq_valid` sampled in sync, with `pos_delay` = d (1 to `cfg_pulse_per`), moves the phase to track in the next cycle. The pulse is expected d cycles after the strobe cycle and then every `cfg_pulse_per` cycles. `fe_en` is high exactly from `cfg_guard` cycles before each expected pulse through `cfg_win` cycles in total (requires `cfg_guard` < `cfg_win` <= period).
- R5: In track only `eng_sfd_en` is set, and no more than one engine enable is ever high.
- R6: An `sfd_hit` sampled in track, with `pos_delay` = d (1 to `cfg_burst_per`), moves the phase to payload. There the windows follow the R4 rule using bursts and `cfg_burst_per`, and only `eng_dec_en` is set. `acq_valid` and `start` in payload do not move the windows or the phase.
- R7: A `pay_done` sampled in payload returns the phase to idle in the next cycle with `fe_en` low.
- R8: In track, the end of each pulse period (slot counter at period-1) counts as one symbol. When `cfg_timeout` symbols have ended without an `sfd_hit`, the phase returns to sync in the cycle after the last one. An `sfd_hit` in that same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin reception (idle only) |
| acq_valid | input | 1 | Code phase acquired strobe |
| sfd_hit | input | 1 | Frame delimiter found strobe |
| pay_done | input | 1 | Payload complete strobe |
| pos_delay | input | CNT_W | Samples from the current strobe to the next pulse or burst |
| cfg_pulse_per | input | CNT_W | Samples between isolated preamble pulses |
| cfg_burst_per | input | CNT_W | Samples between payload bursts |
| cfg_guard | input | CNT_W | Window lead ahead of the expected position |
| cfg_win | input | CNT_W | Window length in samples |
| cfg_timeout | input | TMO_W | Pulse periods allowed in track before falling back |
| fe_en | output | 1 | RF front-end enable |
| phase | output | 2 | Current phase code |
| eng_acq_en | output | 1 | Acquisition engine enable |
| eng_sfd_en | output | 1 | Delimiter search engine enable |
| eng_dec_en | output | 1 | Payload decoder enable |

## Verification
The hardest case to reach is the track timeout, because it needs a run in which acquisition succeeds but the delimiter never comes. The bench reaches it by acquiring with the shortest delay of one sample and a short timeout setting, then holding `sfd_hit` low. It predicts the cycle of the third period end from the strobe cycle alone. A second corner is the payload entry with a delay equal to the whole burst period. During that payload the bench also sends stray `acq_valid` and `start` strobes, so a wrongly preset or reloaded slot counter shows up as a shifted window.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SYNC    = 2'd1,
        PH_TRACK   = 2'd2,
        PH_PAYLOAD = 2'd3
    } phase_e;

    typedef struct packed {
        logic dec;
        logic sfd;
        logic acq;
    } eng_t;

    // Engine selection follows the phase alone.
    function automatic eng_t engines_for(phase_e ph);
        eng_t e;
        e = '0;
        case (ph)
            PH_SYNC:    e.acq = 1'b1;
            PH_TRACK:   e.sfd = 1'b1;
            PH_PAYLOAD: e.dec = 1'b1;
            default:    e = '0;
        endcase
        return e;
    endfunction

    function automatic logic is_gated(phase_e ph);
        return (ph == PH_TRACK) || (ph == PH_PAYLOAD);
    endfunction

endpackage

// File: rtl/fe_seq_fsm.sv
module fe_seq_fsm
    import fe_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   acq_valid,
    input  logic   sfd_hit,
    input  logic   pay_done,
    input  logic   timeout_hit,
    output phase_e phase,
    output logic   ld_acq,
    output logic   ld_sfd
);

    phase_e nxt;

    assign ld_acq = (phase == PH_SYNC)  && acq_valid;
    assign ld_sfd = (phase == PH_TRACK) && sfd_hit;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE:    if (start) nxt = PH_SYNC;
            PH_SYNC:    if (acq_valid) nxt = PH_TRACK;
            PH_TRACK: begin
                if (sfd_hit)          nxt = PH_PAYLOAD;
                else if (timeout_hit) nxt = PH_SYNC;
            end
            PH_PAYLOAD: if (pay_done) nxt = PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

endmodule

// File: rtl/fe_seq_slot_timer.sv
module fe_seq_slot_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] guard,
    input  logic [CNT_W-1:0] delay,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] slot,
    output logic             wrap
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] g_plus;
    logic [EXT_W-1:0] preset_ext;
    logic [CNT_W-1:0] last_slot;

    // The expected position falls on slot == guard, reached 'delay' cycles
    // after the load cycle; the first counted cycle is one after the load.
    assign g_plus    = EXT_W'(guard) + EXT_W'(1);
    assign last_slot = per - CNT_W'(1);

    always_comb begin
        if (g_plus >= EXT_W'(delay))
            preset_ext = g_plus - EXT_W'(delay);
        else
            preset_ext = g_plus + EXT_W'(per) - EXT_W'(delay);
    end

    assign wrap = run && !load && (slot == last_slot);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (load)
            slot <= preset_ext[CNT_W-1:0];
        else if (run)
            slot <= (slot == last_slot) ? '0 : slot + CNT_W'(1);
        else
            slot <= '0;
    end

endmodule

// File: rtl/fe_seq_sfd_timeout.sv
module fe_seq_sfd_timeout #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             wrap,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    localparam int EXT_W = TMO_W + 1;

    logic [TMO_W-1:0] sym_cnt;
    logic [EXT_W-1:0] sym_next;

    assign sym_next = EXT_W'(sym_cnt) + EXT_W'(1);
    assign expired  = active && wrap && (sym_next >= EXT_W'(limit));

    always_ff @(posedge clk) begin
        if (rst || !active)
            sym_cnt <= '0;
        else if (wrap && !sym_next[TMO_W])
            sym_cnt <= sym_next[TMO_W-1:0];
    end

endmodule

// File: rtl/fe_phase_seq.sv
module fe_phase_seq
    import fe_seq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             acq_valid,
    input  logic             sfd_hit,
    input  logic             pay_done,
    input  logic [CNT_W-1:0] pos_delay,
    input  logic [CNT_W-1:0] cfg_pulse_per,
    input  logic [CNT_W-1:0] cfg_burst_per,
    input  logic [CNT_W-1:0] cfg_guard,
    input  logic [CNT_W-1:0] cfg_win,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             fe_en,
    output logic [1:0]       phase,
    output logic             eng_acq_en,
    output logic             eng_sfd_en,
    output logic             eng_dec_en
);

    phase_e           cur_ph;
    logic             ld_acq, ld_sfd, load;
    logic             run, wrap, timeout_hit;
    logic [CNT_W-1:0] slot, per_sel;
    eng_t             eng;

    fe_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .acq_valid  (acq_valid),
        .sfd_hit    (sfd_hit),
        .pay_done   (pay_done),
        .timeout_hit(timeout_hit),
        .phase      (cur_ph),
        .ld_acq     (ld_acq),
        .ld_sfd     (ld_sfd)
    );

    assign load    = ld_acq || ld_sfd;
    assign run     = is_gated(cur_ph);
    assign per_sel = (ld_sfd || (cur_ph == PH_PAYLOAD)) ? cfg_burst_per : cfg_pulse_per;

    fe_seq_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .load (load),
        .guard(cfg_guard),
        .delay(pos_delay),
        .per  (per_sel),
        .slot (slot),
        .wrap (wrap)
    );

    fe_seq_sfd_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .active (cur_ph == PH_TRACK),
        .wrap   (wrap),
        .limit  (cfg_timeout),
        .expired(timeout_hit)
    );

    assign eng        = engines_for(cur_ph);
    assign eng_acq_en = eng.acq;
    assign eng_sfd_en = eng.sfd;
    assign eng_dec_en = eng.dec;
    assign phase      = cur_ph;
    assign fe_en      = (cur_ph == PH_SYNC) || (run && (slot < cfg_win));

endmodule

// File: rtl/fe_phase_seq_chk.sv
module fe_phase_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       acq_valid,
    input logic       sfd_hit,
    input logic       pay_done,
    input logic       fe_en,
    input logic [1:0] phase,
    input logic       eng_acq_en,
    input logic       eng_sfd_en,
    input logic       eng_dec_en
);

    AST_START_TO_SYNC: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && start) |=> (phase == 2'd1)); // R2

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && !start) |=> (phase == 2'd0 && !fe_en)); // R2

    AST_SYNC_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 && !acq_valid) |=> (phase == 2'd1 && fe_en)); // R3

    AST_ACQ_TO_TRACK: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 && acq_valid) |=> (phase == 2'd2)); // R4

    AST_ENG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_acq_en, eng_sfd_en, eng_dec_en})); // R5

    AST_SFD_TO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && sfd_hit) |=> (phase == 2'd3)); // R6

    AST_PAYLOAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && !pay_done) |=> (phase == 2'd3)); // R6

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && pay_done) |=> (phase == 2'd0 && !fe_en)); // R7

endmodule

bind fe_phase_seq fe_phase_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .acq_valid (acq_valid),
    .sfd_hit   (sfd_hit),
    .pay_done  (pay_done),
    .fe_en     (fe_en),
    .phase     (phase),
    .eng_acq_en(eng_acq_en),
    .eng_sfd_en(eng_sfd_en),
    .eng_dec_en(eng_dec_en)
);

// File: tb/fe_phase_seq_bench.sv
`timescale 1ns/1ps
module fe_phase_seq_bench;

    localparam int CW = 12;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, acq_valid = 1'b0, sfd_hit = 1'b0, pay_done = 1'b0;
    logic [CW-1:0] pos_delay = '0;
    logic [CW-1:0] cfg_pulse_per = CW'(16), cfg_burst_per = CW'(24);
    logic [CW-1:0] cfg_guard = CW'(2), cfg_win = CW'(5);
    logic [TW-1:0] cfg_timeout = TW'(8);
    logic          fe_en, eng_acq_en, eng_sfd_en, eng_dec_en;
    logic [1:0]    phase;

    fe_phase_seq #(.CNT_W(CW), .TMO_W(TW)) u_fe_phase_seq (
        .clk(clk), .rst(rst), .start(start), .acq_valid(acq_valid),
        .sfd_hit(sfd_hit), .pay_done(pay_done), .pos_delay(pos_delay),
        .cfg_pulse_per(cfg_pulse_per), .cfg_burst_per(cfg_burst_per),
        .cfg_guard(cfg_guard), .cfg_win(cfg_win), .cfg_timeout(cfg_timeout),
        .fe_en(fe_en), .phase(phase), .eng_acq_en(eng_acq_en),
        .eng_sfd_en(eng_sfd_en), .eng_dec_en(eng_dec_en)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int       cyc;
        bit       fe;
        bit [1:0] ph;
        bit [2:0] eng;   // {dec, sfd, acq}
        string    tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int pmod(int a, int m);
        return ((a % m) + m) % m;
    endfunction

    task automatic check(string tag, bit fe_a, bit [1:0] ph_a, bit [2:0] en_a,
                         bit fe_e, bit [1:0] ph_e, bit [2:0] en_e, int c);
        n_run++;
        if (fe_a !== fe_e || ph_a !== ph_e || en_a !== en_e) begin
            n_fail++;
            $display("FAIL %s cyc %0d: fe/phase/eng actual %0b/%0d/%03b expected %0b/%0d/%03b",
                     tag, c, fe_a, ph_a, en_a, fe_e, ph_e, en_e);
        end
    endtask

    // Monitor: pops expected items when their cycle comes up.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t it;
            it = q.pop_front();
            if (it.cyc == cyc)
                check(it.tag, fe_en, phase, {eng_dec_en, eng_sfd_en, eng_acq_en},
                      it.fe, it.ph, it.eng, cyc);
        end
    end

    task automatic push_const(int from, int n, bit fe, bit [1:0] ph, bit [2:0] en, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            it.cyc = from + i; it.fe = fe; it.ph = ph; it.eng = en; it.tag = tag;
            q.push_back(it);
        end
    endtask

    // Windows open g cycles before each expected position and last w cycles.
    task automatic push_win(int from, int n, int anchor, int per, int g, int w,
                            bit [1:0] ph, bit [2:0] en, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            it.cyc = from + i;
            it.fe  = pmod(from + i - anchor + g, per) < w;
            it.ph  = ph; it.eng = en; it.tag = tag;
            q.push_back(it);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic run_to(int c);
        while (cyc < c) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        finish_run();
    end

    initial begin
        int s, cw, wraps;
        // R1: reset state, during reset and right after release
        repeat (3) tick();
        @(negedge clk);
        check("R1 in reset", fe_en, phase, {eng_dec_en, eng_sfd_en, eng_acq_en}, 0, 2'd0, 3'b000, cyc);
        tick();
        rst = 1'b0;
        s = cyc;
        push_const(s + 1, 2, 0, 2'd0, 3'b000, "R1 after reset");
        run_to(s + 2);

        // R2: strobes other than start are ignored in idle
        s = cyc;
        push_const(s + 1, 6, 0, 2'd0, 3'b000, "R2 idle ignores strobes");
        acq_valid = 1; sfd_hit = 1; pay_done = 1; pos_delay = CW'(3);
        tick();
        acq_valid = 0; sfd_hit = 0; pay_done = 0;
        run_to(s + 6);

        // R2/R3: start, then continuous on with stray strobes ignored
        s = cyc;
        push_const(s + 1, 30, 1, 2'd1, 3'b001, "R3 sync always on");
        start = 1; tick(); start = 0;
        run_to(s + 10);
        start = 1; sfd_hit = 1; pay_done = 1; tick();
        start = 0; sfd_hit = 0; pay_done = 0;
        run_to(s + 30);

        // R4/R5: acquire, next pulse 5 cycles away, period 16
        s = cyc;
        push_win(s + 1, 40, s + 5, 16, 2, 5, 2'd2, 3'b010, "R4 R5 track windows");
        acq_valid = 1; pos_delay = CW'(5); tick(); acq_valid = 0;
        run_to(s + 40);

        // R6: delimiter, burst a full period away (boundary d = period)
        s = cyc;
        push_win(s + 1, 60, s + 24, 24, 2, 5, 2'd3, 3'b100, "R6 payload windows");
        sfd_hit = 1; pos_delay = CW'(24); tick(); sfd_hit = 0;
        run_to(s + 20);
        acq_valid = 1; start = 1; pos_delay = CW'(7); tick();
        acq_valid = 0; start = 0;
        run_to(s + 60);

        // R7: payload done returns to idle
        s = cyc;
        push_const(s + 1, 6, 0, 2'd0, 3'b000, "R7 back to idle");
        pay_done = 1; tick(); pay_done = 0;
        run_to(s + 6);

        // R8: timeout after 3 pulse periods with no delimiter, delay 1
        cfg_timeout = TW'(3);
        s = cyc;
        push_const(s + 1, 5, 1, 2'd1, 3'b001, "R8 sync before acquire");
        start = 1; tick(); start = 0;
        run_to(s + 5);
        s = cyc;
        cw = s; wraps = 0;
        while (wraps < 3) begin
            cw++;
            if (pmod(cw - (s + 1) + 2, 16) == 15) wraps++;
        end
        push_win(s + 1, cw - s, s + 1, 16, 2, 5, 2'd2, 3'b010, "R8 track before timeout");
        push_const(cw + 1, 8, 1, 2'd1, 3'b001, "R8 fall back to sync");
        acq_valid = 1; pos_delay = CW'(1); tick(); acq_valid = 0;
        run_to(cw + 9);
        tick();
        finish_run();
    end

endmodule